// File: doc/BRIEF.md
# AXI-lite Memory Read Responder

This block is the read side of an AXI-lite slave that returns words from a small word-addressed memory. A master offers an address on the read address channel. The block answers on the read data channel exactly one clock after it accepts the address. While the master keeps accepting responses, it can retire one read on every clock.

The master may stall the response channel at any time. The address-ready output is a registered signal, so one more request can be accepted after a stall begins. A one-entry skid register captures that request. The address-ready output is low exactly when the skid register holds a request. When the stall clears, the held request becomes the next response, and the block accepts addresses again one clock later. The memory contents are loaded from a fixed formula on reset. The response code is always OKAY.

Top module: `axil_rd_resp`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ar_ready_o` is 1 and `r_valid_o` is 0.
- R2: A request accepted on a clock edge (`ar_valid_i && ar_ready_o`) makes `r_valid_o` high after that same edge. When `r_ready_i` is held high, a new request is accepted on every clock and `ar_ready_o` never drops.
- R3: If `r_valid_o` is high and `r_ready_i` is low at an edge, then after that edge `r_valid_o` is still high and `r_data_o` is unchanged.
- R4: If a request is accepted in a cycle where the response is stalled, `ar_ready_o` is 0 after that edge. No accepted request is lost, and the responses come back in acceptance order.
- R5: If the response is stalled, `ar_ready_o` is high and `ar_valid_i` is low, then `ar_ready_o` stays high after the edge.
- R6: If `ar_ready_o` is low in a cycle where the response is not stalled, then `ar_ready_o` is 1 after that edge. The held request is the next response returned.
- R7: `r_resp_o` is always 2'b00 (OKAY).
- R8: The response to address `a` is word `i = a[IDX_W+1:2]`, where IDX_W = log2(DEPTH). Its value is `(i * 32'h0100_0193) ^ 32'h5A5A_5A5A`, truncated to 32 bits. Address bits [1:0] and the bits above IDX_W+1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready (registered) |
| ar_addr_i | input | ADDR_W | Byte address of the read |
| r_valid_o | output | 1 | Read response valid |
| r_ready_i | input | 1 | Read response accepted by master |
| r_data_o | output | 32 | Read data |
| r_resp_o | output | 2 | Response code, always OKAY |

## Verification
Each result in this block is due one edge after the cycle that causes it: the response for an accepted address, the drop of `ar_ready_o`, and the release after a drain. The hold under a stall is also due one edge later. The bench drives inputs on the falling edge and records the handshake and stall conditions of that cycle. It checks the predicted outputs on the next falling edge. Data is compared when the response handshake takes place, against a queue of expected words built at address acceptance, so ordering and loss are checked across any number of stall cycles.

// File: rtl/axil_rd_pkg.sv
package axil_rd_pkg;
  typedef logic [31:0] word_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Reset-time contents of word idx
  function automatic word_t init_word(input int unsigned idx);
    word_t prod;
    prod = 32'(idx * 32'h0100_0193);
    return prod ^ 32'h5A5A_5A5A;
  endfunction
endpackage

// File: rtl/ard_skid.sv
module ard_skid #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ar_valid_i,
  input  logic [IDX_W-1:0] ar_idx_i,
  input  logic             stall_i,
  output logic             ar_ready_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             req_pend_o
);
  logic             ready_q;
  logic [IDX_W-1:0] skid_q;

  // ready low <=> skid holds a request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
    end else if (!stall_i) begin
      ready_q <= 1'b1;
    end else if (ar_valid_i) begin
      ready_q <= 1'b0;
    end
  end

  // captured whenever ready; a don't-care when nothing is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skid_q <= '0;
    end else if (ready_q) begin
      skid_q <= ar_idx_i;
    end
  end

  assign ar_ready_o = ready_q;
  assign rd_idx_o   = ready_q ? ar_idx_i : skid_q;
  assign req_pend_o = ar_valid_i | ~ready_q;
endmodule

// File: rtl/ard_mem.sv
module ard_mem
  import axil_rd_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output word_t            rd_data_o
);
  word_t mem_q [DEPTH];
  word_t data_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= init_word(g);
    end
  end

  // extra reads are harmless; read whenever output can move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (rd_en_i) begin
      data_q <= mem_q[rd_idx_i];
    end
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/ard_resp.sv
module ard_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_pend_i,
  input  logic r_ready_i,
  output logic r_valid_o,
  output logic stall_o
);
  logic valid_q;

  assign stall_o = valid_q & ~r_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= stall_o | req_pend_i;
  end

  assign r_valid_o = valid_q;
endmodule

// File: rtl/axil_rd_resp.sv
module axil_rd_resp
  import axil_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ADDR_W-1:0] ar_addr_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [31:0]       r_data_o,
  output logic [1:0]        r_resp_o
);
  logic             stall;
  logic             req_pend;
  logic [IDX_W-1:0] rd_idx;

  if (ADDR_W > IDX_W + 2) begin : g_hi
    logic unused_addr;
    assign unused_addr = ^{ar_addr_i[ADDR_W-1:IDX_W+2], ar_addr_i[1:0]};
  end else begin : g_lo
    logic unused_addr;
    assign unused_addr = ^ar_addr_i[1:0];
  end

  ard_skid #(.IDX_W(IDX_W)) u_skid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ar_valid_i (ar_valid_i),
    .ar_idx_i   (ar_addr_i[IDX_W+1:2]),
    .stall_i    (stall),
    .ar_ready_o (ar_ready_o),
    .rd_idx_o   (rd_idx),
    .req_pend_o (req_pend)
  );

  ard_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (~stall),
    .rd_idx_i  (rd_idx),
    .rd_data_o (r_data_o)
  );

  ard_resp u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_pend_i (req_pend),
    .r_ready_i  (r_ready_i),
    .r_valid_o  (r_valid_o),
    .stall_o    (stall)
  );

  assign r_resp_o = RESP_OKAY;
endmodule

// File: rtl/ard_checker.sv
module ard_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ar_valid_i,
  input logic        ar_ready_o,
  input logic        r_valid_o,
  input logic        r_ready_i,
  input logic [31:0] r_data_o,
  input logic [1:0]  r_resp_o
);
  p_accept_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_i && ar_ready_o |=> r_valid_o);

  p_hold_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_data_o));

  p_skid_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i && ar_valid_i && ar_ready_o |=> !ar_ready_o);

  p_skid_has_resp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ar_ready_o |-> r_valid_o);

  p_stall_keeps_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i && ar_ready_o && !ar_valid_i |=> ar_ready_o);

  p_drain_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ar_ready_o && r_ready_i |=> ar_ready_o);

  p_resp_okay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_resp_o == 2'b00);
endmodule

bind axil_rd_resp ard_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ar_valid_i (ar_valid_i),
  .ar_ready_o (ar_ready_o),
  .r_valid_o  (r_valid_o),
  .r_ready_i  (r_ready_i),
  .r_data_o   (r_data_o),
  .r_resp_o   (r_resp_o)
);

// File: tb/tb_axil_rd_resp.sv
`timescale 1ns/1ps
module tb_axil_rd_resp;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ar_valid = 1'b0;
  logic              ar_ready;
  logic [ADDR_W-1:0] ar_addr = '0;
  logic              r_valid;
  logic              r_ready = 1'b0;
  logic [31:0]       r_data;
  logic [1:0]        r_resp;

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;
  int mode   = 0;   // 0 full rate, 1 random, 2 drain
  int pct_av = 50;
  int pct_rr = 50;
  int cyc_in_mode = 0;

  logic [31:0] expq[$];
  bit          exp_rv, exp_hold, exp_ar_lo, exp_ar_keep, exp_ar_rel;
  logic [31:0] held_data;

  always #10 clk = ~clk;

  axil_rd_resp #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ar_valid_i(ar_valid), .ar_ready_o(ar_ready),
    .ar_addr_i(ar_addr), .r_valid_o(r_valid), .r_ready_i(r_ready),
    .r_data_o(r_data), .r_resp_o(r_resp)
  );

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a);
    logic [31:0] idx;
    idx = 32'(a[IDX_W+1:2]);
    return 32'(idx * 32'h0100_0193) ^ 32'h5A5A_5A5A;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      bit acc, stall;
      // outputs due from last edge
      if (exp_rv)      check(r_valid == 1'b1, "R2 r_valid after accept", 32'(r_valid), 1);
      if (exp_hold)    check(r_valid && r_data == held_data, "R3 hold under stall", r_data, held_data);
      if (exp_ar_lo)   check(ar_ready == 1'b0, "R4 ar_ready drop", 32'(ar_ready), 0);
      if (exp_ar_keep) check(ar_ready == 1'b1, "R5 ar_ready kept", 32'(ar_ready), 1);
      if (exp_ar_rel)  check(ar_ready == 1'b1, "R6 ar_ready release", 32'(ar_ready), 1);
      check(r_resp == 2'b00, "R7 resp okay", 32'(r_resp), 0);
      if (mode == 0 && cyc_in_mode > 1)
        check(ar_ready && r_valid, "R2 full rate", 32'({ar_ready, r_valid}), 3);

      // drive this cycle
      case (mode)
        0: begin ar_valid = 1'b1; r_ready = 1'b1; end
        1: begin
          ar_valid = ($urandom % 100) < pct_av;
          r_ready  = ($urandom % 100) < pct_rr;
        end
        default: begin ar_valid = 1'b0; r_ready = 1'b1; end
      endcase
      ar_addr = ADDR_W'($urandom);
      cyc_in_mode++;

      acc   = ar_valid && ar_ready;
      stall = r_valid && !r_ready;
      if (r_valid && r_ready) begin
        if (expq.size() == 0) check(1'b0, "R4 unexpected response", r_data, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          check(r_data == e, "R8 data/order", r_data, e);
        end
      end
      if (acc) expq.push_back(exp_word(ar_addr));
      exp_rv      = acc;
      exp_hold    = stall;
      held_data   = r_data;
      exp_ar_lo   = stall && acc;
      exp_ar_keep = stall && ar_ready && !ar_valid;
      exp_ar_rel  = !ar_ready && !stall;
    end
  end

  task automatic run_mode(input int m, input int n, input int pa, input int pr);
    mode = m; pct_av = pa; pct_rr = pr; cyc_in_mode = 0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(ar_ready == 1'b1, "R1 reset ar_ready", 32'(ar_ready), 1);
    check(r_valid == 1'b0, "R1 reset r_valid", 32'(r_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ar_ready == 1'b1 && r_valid == 1'b0, "R1 after release",
          32'({ar_ready, r_valid}), 2);
    run = 1'b1;
    run_mode(0, 20, 100, 100);
    run_mode(1, 3000, 85, 30);
    run_mode(1, 3000, 50, 75);
    run_mode(0, 10, 100, 100);
    run_mode(1, 2000, 95, 10);
    run_mode(2, 12, 0, 100);
    @(negedge clk);
    run = 1'b0;
    check(expq.size() == 0, "R4 nothing lost", 32'(expq.size()), 0);
    check(!r_valid && ar_ready, "R6 idle after drain", 32'({ar_ready, r_valid}), 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule